// File: doc/BRIEF.md
# Video Gate Register Write Decoder

This block sits on the I/O write side of an 8-bit processor bus. It watches byte writes and sends each selected write to one of four internal functions. A write can select a pen, load a colour into the selected pen, set the display mode and ROM paging controls, or load the RAM banking byte. The colour store holds sixteen pen entries and one border entry. Colour loads go through a pen pointer that keeps its value between writes, so software selects an entry once and can then load it as often as it likes.

The block does not switch the display mode at once. A mode request is held as pending. It is copied into the active mode only when the horizontal sync input rises, so pixel logic downstream never sees a mode change in the middle of a line. A control write can also ask for the raster interrupt counter to restart. That request leaves the block as a pulse one cycle long. The counter itself belongs to a neighbouring block.

Top module: `vgate_regs`

## Requirements
- R1: A write is accepted only when `ioWrEn` is 1, address bit 15 is 0 and address bit 14 is 1. All other address bits have no effect. Any other write changes no output and no colour entry.
- R2: In an accepted write, data bits 7:6 choose the function: 00 pen select, 01 colour load, 10 control, 11 bank load. No other function is touched.
- R3: In a pen-select write with data bit 4 set, the pointer selects the border entry (index 16) and bits 3:0 are ignored. With bit 4 clear, bits 3:0 select pen 0 to 15.
- R4: The pen pointer keeps its value until the next pen-select write. Several colour loads in a row all land in the same entry.
- R5: A colour load stores data bits 4:0 into the entry the pointer selects. The new value shows on `rdColour` for that index in the cycle after the write edge.
- R6: A control write sets `modeReq` to data bits 1:0, `lowerRomEn` to the inverse of bit 2 and `upperRomEn` to the inverse of bit 3. All three are visible in the cycle after the write.
- R7: `irqCntClr` is high for exactly the one cycle after each control write that has data bit 4 set, and is low at every other time.
- R8: `modeActive` changes only at a clock edge where `hsync` is 1 and was 0 at the previous edge. At that edge it takes the `modeReq` value held before the edge, so a control write on the same edge is not yet included.
- R9: A bank load stores the full data byte on `ramBank`.
- R10: After reset, every colour entry, the pen pointer, `modeReq`, `modeActive` and `ramBank` are 0, both ROM enables are 1, and `irqCntClr` is 0.
- R11: A `rdIdx` above 16 reads 0 on `rdColour`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioAddr | input | 16 | I/O address |
| ioData | input | 8 | I/O write data |
| hsync | input | 1 | Horizontal sync from the timing generator |
| rdIdx | input | 5 | Colour store read index (0-15 pens, 16 border) |
| rdColour | output | 5 | Colour code stored at `rdIdx` |
| modeReq | output | 2 | Pending display mode |
| modeActive | output | 2 | Display mode applied at the last sync rise |
| upperRomEn | output | 1 | Upper ROM paging enabled |
| lowerRomEn | output | 1 | Lower ROM paging enabled |
| ramBank | output | 8 | RAM banking byte |
| irqCntClr | output | 1 | One-cycle request to restart the interrupt counter |

## Verification
The assertions check on every cycle the things that depend only on the ports. They cover the address qualifier that blocks unselected writes, the control and bank fields that follow an accepted write, the one-cycle clear pulse, and the rule that the active mode moves only on a sync rise and takes the older pending value. The colour store is reached only through the pen pointer, so the pointer's stickiness, the border redirect and the masking of the upper data bits show up only in the bench's scenarios. In those scenarios a behavioural model follows every write and every entry is read back through `rdIdx`.

// File: rtl/vgate_pkg.sv
package vgate_pkg;

  // Function codes carried in data bits 7:6
  localparam logic [1:0] FN_PEN  = 2'b00;
  localparam logic [1:0] FN_INK  = 2'b01;
  localparam logic [1:0] FN_CTRL = 2'b10;
  localparam logic [1:0] FN_BANK = 2'b11;

  // Fixed data bit positions used by the register functions
  localparam int FN_HI      = 7;
  localparam int FN_LO      = 6;
  localparam int BORDER_BIT = 4;
  localparam int CLR_BIT    = 4;
  localparam int UROM_BIT   = 3;
  localparam int LROM_BIT   = 2;

  typedef struct packed {
    logic penWr;
    logic inkWr;
    logic ctrlWr;
    logic bankWr;
    logic hsyncRise;
  } strobe_t;

endpackage

// File: rtl/vgate_ctrl.sv
module vgate_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ioWrEn,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic [1:0]              fnCode,
  input  logic                    hsync,
  output vgate_pkg::strobe_t      stb
);
  import vgate_pkg::*;

  localparam int SEL_LO_BIT = ADDR_W - 2;
  localparam int SEL_HI_BIT = ADDR_W - 1;

  logic hsyncQ;
  logic chipSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsyncQ <= 1'b0;
    else       hsyncQ <= hsync;
  end

  assign chipSel = ioWrEn && !ioAddr[SEL_HI_BIT] && ioAddr[SEL_LO_BIT];

  always_comb begin
    stb           = '0;
    stb.hsyncRise = hsync && !hsyncQ;
    if (chipSel) begin
      unique case (fnCode)
        FN_PEN:  stb.penWr  = 1'b1;
        FN_INK:  stb.inkWr  = 1'b1;
        FN_CTRL: stb.ctrlWr = 1'b1;
        default: stb.bankWr = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/vgate_datapath.sv
module vgate_datapath #(
  parameter int NUM_PENS = 16,
  parameter int COLOUR_W = 5,
  parameter int MODE_W   = 2,
  localparam int ENTRIES = NUM_PENS + 1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vgate_pkg::strobe_t   stb,
  input  logic [7:0]           wrData,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [COLOUR_W-1:0]  rdColour,
  output logic [MODE_W-1:0]    modeReq,
  output logic [MODE_W-1:0]    modeActive,
  output logic                 upperRomEn,
  output logic                 lowerRomEn,
  output logic [7:0]           ramBank,
  output logic                 irqCntClr
);
  import vgate_pkg::*;

  localparam int PEN_W = $clog2(NUM_PENS);
  localparam logic [IDX_W-1:0] BORDER_IDX = IDX_W'(NUM_PENS);

  logic [IDX_W-1:0]    penPtr;
  logic [COLOUR_W-1:0] colourFile [ENTRIES];

  // Sticky pen pointer; the border flag overrides the pen number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      penPtr <= '0;
    end else if (stb.penWr) begin
      if (wrData[BORDER_BIT]) penPtr <= BORDER_IDX;
      else                    penPtr <= IDX_W'(wrData[PEN_W-1:0]);
    end
  end

  // One write-enabled register per colour entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        colourFile[e] <= '0;
      else if (stb.inkWr && penPtr == IDX_W'(e))
        colourFile[e] <= wrData[COLOUR_W-1:0];
    end
  end

  always_comb begin
    rdColour = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rdIdx == IDX_W'(e)) rdColour = colourFile[e];
    end
  end

  // Control fields, bank byte and the clear pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReq    <= '0;
      upperRomEn <= 1'b1;
      lowerRomEn <= 1'b1;
      ramBank    <= '0;
      irqCntClr  <= 1'b0;
    end else begin
      irqCntClr <= stb.ctrlWr && wrData[CLR_BIT];
      if (stb.ctrlWr) begin
        modeReq    <= wrData[MODE_W-1:0];
        upperRomEn <= !wrData[UROM_BIT];
        lowerRomEn <= !wrData[LROM_BIT];
      end
      if (stb.bankWr) ramBank <= wrData;
    end
  end

  // Pending mode becomes active only on a sync rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeActive <= '0;
    else if (stb.hsyncRise) modeActive <= modeReq;
  end

endmodule

// File: rtl/vgate_regs.sv
module vgate_regs #(
  parameter int ADDR_W   = 16,
  parameter int NUM_PENS = 16,
  parameter int COLOUR_W = 5,
  parameter int MODE_W   = 2,
  localparam int IDX_W   = $clog2(NUM_PENS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioWrEn,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [7:0]          ioData,
  input  logic                hsync,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [COLOUR_W-1:0] rdColour,
  output logic [MODE_W-1:0]   modeReq,
  output logic [MODE_W-1:0]   modeActive,
  output logic                upperRomEn,
  output logic                lowerRomEn,
  output logic [7:0]          ramBank,
  output logic                irqCntClr
);
  import vgate_pkg::*;

  strobe_t stb;

  vgate_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ioWrEn (ioWrEn),
    .ioAddr (ioAddr),
    .fnCode (ioData[FN_HI:FN_LO]),
    .hsync  (hsync),
    .stb    (stb)
  );

  vgate_datapath #(
    .NUM_PENS (NUM_PENS),
    .COLOUR_W (COLOUR_W),
    .MODE_W   (MODE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (ioData),
    .rdIdx      (rdIdx),
    .rdColour   (rdColour),
    .modeReq    (modeReq),
    .modeActive (modeActive),
    .upperRomEn (upperRomEn),
    .lowerRomEn (lowerRomEn),
    .ramBank    (ramBank),
    .irqCntClr  (irqCntClr)
  );

endmodule

// File: rtl/vgate_regs_chk.sv
module vgate_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWrEn,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [7:0]        ioData,
  input logic              hsync,
  input logic [MODE_W-1:0] modeReq,
  input logic [MODE_W-1:0] modeActive,
  input logic              upperRomEn,
  input logic              lowerRomEn,
  input logic [7:0]        ramBank,
  input logic              irqCntClr
);

  logic hit;
  logic ctrlHit;
  logic bankHit;

  assign hit     = ioWrEn && !ioAddr[ADDR_W-1] && ioAddr[ADDR_W-2];
  assign ctrlHit = hit && ioData[7:6] == 2'b10;
  assign bankHit = hit && ioData[7:6] == 2'b11;

  assert_unselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && !hit) |=> ($stable(modeReq) && $stable(ramBank) &&
                          $stable(upperRomEn) && $stable(lowerRomEn) && !irqCntClr));

  assert_ctrl_fields_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> (modeReq == $past(ioData[MODE_W-1:0]) &&
                 upperRomEn == !$past(ioData[3]) &&
                 lowerRomEn == !$past(ioData[2])));

  assert_clr_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && ioData[4]) |=> irqCntClr);

  assert_clr_has_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqCntClr |-> $past(ctrlHit && ioData[4]));

  assert_mode_on_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |=> modeActive == $past(modeReq));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(hsync) |=> $stable(modeActive));

  assert_bank_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    bankHit |=> ramBank == $past(ioData));

endmodule

bind vgate_regs vgate_regs_chk #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .ioWrEn     (ioWrEn),
  .ioAddr     (ioAddr),
  .ioData     (ioData),
  .hsync      (hsync),
  .modeReq    (modeReq),
  .modeActive (modeActive),
  .upperRomEn (upperRomEn),
  .lowerRomEn (lowerRomEn),
  .ramBank    (ramBank),
  .irqCntClr  (irqCntClr)
);

// File: tb/vgate_regs_tb_top.sv
module vgate_regs_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic [7:0]  ioData = 8'h0;
  logic        hsync = 1'b0;
  logic [4:0]  rdIdx = 5'd0;
  logic [4:0]  rdColour;
  logic [1:0]  modeReq;
  logic [1:0]  modeActive;
  logic        upperRomEn;
  logic        lowerRomEn;
  logic [7:0]  ramBank;
  logic        irqCntClr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vgate_regs dut_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioData(ioData),
    .hsync(hsync), .rdIdx(rdIdx), .rdColour(rdColour), .modeReq(modeReq),
    .modeActive(modeActive), .upperRomEn(upperRomEn), .lowerRomEn(lowerRomEn),
    .ramBank(ramBank), .irqCntClr(irqCntClr)
  );

  // Behavioural reference model
  int refColour [17];
  int refPen, refModeReq, refModeAct, refBank;
  bit refUpper, refLower, refClr, refHsPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (refColour[k]) refColour[k] = 0;
      refPen = 0; refModeReq = 0; refModeAct = 0; refBank = 0;
      refUpper = 1; refLower = 1; refClr = 0; refHsPrev = 0;
    end else begin
      if (hsync && !refHsPrev) refModeAct = refModeReq;
      refHsPrev = hsync;
      refClr = 0;
      if (ioWrEn && ioAddr[15] == 1'b0 && ioAddr[14] == 1'b1) begin
        case (ioData[7:6])
          2'b00: refPen = ioData[4] ? 16 : int'(ioData[3:0]);
          2'b01: refColour[refPen] = int'(ioData[4:0]);
          2'b10: begin
            refModeReq = int'(ioData[1:0]);
            refLower = !ioData[2];
            refUpper = !ioData[3];
            refClr = ioData[4];
          end
          default: refBank = int'(ioData);
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expCol;
      expCol = (rdIdx <= 5'd16) ? refColour[rdIdx] : 0;
      check(int'(rdColour) == expCol, (rdIdx > 5'd16) ? "R11" : "R5",
            int'(rdColour), expCol);
      check(int'(modeReq) == refModeReq, "R6", int'(modeReq), refModeReq);
      check(upperRomEn == refUpper, "R6", int'(upperRomEn), int'(refUpper));
      check(lowerRomEn == refLower, "R6", int'(lowerRomEn), int'(refLower));
      check(irqCntClr == refClr, "R7", int'(irqCntClr), int'(refClr));
      check(int'(modeActive) == refModeAct, "R8", int'(modeActive), refModeAct);
      check(int'(ramBank) == refBank, "R9", int'(ramBank), refBank);
    end
  end

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
      summary();
    end
  end

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ioWrEn = 1'b1; ioAddr = a; ioData = d;
    @(posedge clk); #1;
    ioWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic sweepRead();
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      rdIdx = 5'(i);
    end
    @(posedge clk); #1;
  endtask

  localparam logic [15:0] SEL = 16'h7F00;

  initial begin
    idle(3);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check(rdColour == 5'd0, "R10", int'(rdColour), 0);
    check(modeReq == 2'd0 && modeActive == 2'd0, "R10", int'(modeReq), 0);
    check(upperRomEn && lowerRomEn, "R10", int'({upperRomEn, lowerRomEn}), 3);
    check(ramBank == 8'd0 && !irqCntClr, "R10", int'(ramBank), 0);

    // R3/R5: pen 3 gets a colour
    ioWrite(SEL, 8'h03);
    ioWrite(SEL, 8'h55);
    rdIdx = 5'd3; idle(1);
    // R3: border select with low bits set, bits 3:0 ignored
    ioWrite(SEL, 8'h1F);
    ioWrite(SEL, 8'h4A);
    rdIdx = 5'd16; idle(1);
    rdIdx = 5'd15; idle(1);
    // R4: pointer sticks across several colour loads; upper bits masked (R5)
    ioWrite(SEL, 8'h09);
    ioWrite(SEL, 8'h41);
    ioWrite(SEL, 8'h7F);
    rdIdx = 5'd9; idle(1);
    // R6/R7: control with clear, then without
    ioWrite(SEL, 8'h9E);
    ioWrite(SEL, 8'h81);
    ioWrite(SEL, 8'h90);
    // R9: bank byte
    ioWrite(SEL, 8'hC7);
    // R1: unselected address patterns, every function
    ioWrite(16'hC000, 8'h02);
    ioWrite(16'hC000, 8'h5F);
    ioWrite(16'h0000, 8'h9F);
    ioWrite(16'hBFFF, 8'hFF);
    ioWrite(16'h8000, 8'h00);
    // R1: other address bits do not matter when selected
    ioWrite(16'h4000, 8'h42);
    ioWrite(16'h7FFF, 8'hC1);
    // R1: strobe low with selected address
    @(posedge clk); #1; ioAddr = SEL; ioData = 8'h83; idle(2);
    // R8: sync rise applies pending mode
    ioWrite(SEL, 8'h82);
    @(posedge clk); #1; hsync = 1'b1; idle(2);
    @(posedge clk); #1; hsync = 1'b0;
    // R8: control write on the same edge as a sync rise
    @(posedge clk); #1;
    ioWrEn = 1'b1; ioAddr = SEL; ioData = 8'h93; hsync = 1'b1;
    @(posedge clk); #1;
    ioWrEn = 1'b0;
    idle(2);
    @(posedge clk); #1; hsync = 1'b0;
    @(posedge clk); #1; hsync = 1'b1;
    @(posedge clk); #1; hsync = 1'b0;
    // R2: pen 0 and border distinct; R11 via sweep
    ioWrite(SEL, 8'h00);
    ioWrite(SEL, 8'h5D);
    ioWrite(SEL, 8'h10);
    ioWrite(SEL, 8'h46);
    sweepRead();
    idle(2);
    summary();
  end

endmodule